// File: doc/BRIEF.md
# Service-Qualified System Enable

This block drives the active-low system enable that gates critical actuators such as motor drivers. It takes two signals from a window watchdog controller. One is the system reset level. The other is a one-cycle strobe that marks a service landing inside the open window. The enable is withheld after every reset of any origin: a power-up sequence, a voltage drop, an early service or a missed service. It is granted only once the processor has serviced the watchdog correctly a set number of times in a row. With this gating, a system that keeps resetting cannot energise its actuators each time it restarts.

Inside, a saturating counter records consecutive correct services. Any active reset level clears it. It stops counting at the required total, which defaults to three. The enable is driven active while the counter holds that total and reset is inactive. The reset level reaches the output without passing through a register, so a voltage drop drops the enable in the same cycle.

Top module: `ensvc_top`

## Requirements
- R1: While `por_n` is low, `en_n` is 1. After `por_n` rises, the service count starts at zero.
- R2: In every cycle where `wd_rst_n` is low, `en_n` is 1 in that same cycle, with no clock edge needed.
- R3: A clock edge that samples `wd_rst_n` low clears the consecutive-service count to zero, whatever the count was before.
- R4: A `svc_ok` strobe sampled while `wd_rst_n` is low does not count. This holds even when it falls in the same cycle as the reset assertion.
- R5: When the NEED-th consecutive strobe (default 3) is sampled with `wd_rst_n` high, `en_n` goes to 0 from the next cycle on, as long as `wd_rst_n` stays high.
- R6: While fewer than NEED strobes have been sampled since the last reset, `en_n` stays 1. In cycles without a strobe the count holds.
- R7: The count saturates at NEED. Further strobes keep `en_n` at 0.
- R8: After the enable has been granted, one reset cycle withdraws it. A full NEED strobes are then needed again to regain it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| wd_rst_n | input | 1 | Reset level from the watchdog controller, active low |
| svc_ok | input | 1 | One-cycle strobe: a service fell inside the open window |
| en_n | output | 1 | System enable, active low |

## Verification
Two functions can land in the same cycle: counting a correct service and clearing on reset. The bench drives `svc_ok` high in the cycle where `wd_rst_n` falls, and also while reset is held. It then checks that the enable stays withdrawn until NEED further strobes have been sampled with reset inactive. The random phase raises the chance of this overlap by pulsing reset at a low rate on top of frequent strobes. The reference model in the bench judges every cycle and gives the clear priority over the increment.

// File: rtl/ensvc_pkg.sv
package ensvc_pkg;

    localparam int unsigned DEF_NEED = 3;

    // Counter width large enough to hold the value `need`.
    function automatic int unsigned cnt_bits(input int unsigned need);
        return (need < 2) ? 1 : $clog2(need + 1);
    endfunction

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_HOLD  = 2'd1,
        OP_STEP  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/ensvc_arbiter.sv
module ensvc_arbiter
    import ensvc_pkg::*;
(
    input  logic    rst_act,
    input  logic    svc_ok,
    input  logic    at_top,
    output cnt_op_e op
);
    // Reset clear outranks a service; a full count ignores further services.
    always_comb begin
        if (rst_act)
            op = OP_CLEAR;
        else if (svc_ok && !at_top)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ensvc_counter.sv
module ensvc_counter
    import ensvc_pkg::*;
#(
    parameter int unsigned W = 2
) (
    input  cnt_op_e        op,
    input  logic [W-1:0]   cnt,
    output logic [W-1:0]   cnt_nxt
);
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_nxt = '0;
            OP_STEP:  cnt_nxt = cnt + W'(1);
            default:  cnt_nxt = cnt;
        endcase
    end
endmodule

// File: rtl/ensvc_gate.sv
module ensvc_gate (
    input  logic rst_act,
    input  logic at_top,
    output logic en_n
);
    // Reset level bypasses the register so a voltage drop acts at once.
    assign en_n = rst_act | ~at_top;
endmodule

// File: rtl/ensvc_top.sv
module ensvc_top
    import ensvc_pkg::*;
#(
    parameter int unsigned NEED = DEF_NEED,
    localparam int unsigned W   = cnt_bits(NEED)
) (
    input  logic clk,
    input  logic por_n,
    input  logic wd_rst_n,
    input  logic svc_ok,
    output logic en_n
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic         rst_act;
    logic         at_top;
    cnt_op_e      op;

    assign cnt_q   = st_q.cnt;
    assign rst_act = ~wd_rst_n;
    assign at_top  = (cnt_q == W'(NEED));

    ensvc_arbiter i_arb (
        .rst_act (rst_act),
        .svc_ok  (svc_ok),
        .at_top  (at_top),
        .op      (op)
    );

    ensvc_counter #(.W(W)) i_cnt (
        .op      (op),
        .cnt     (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    ensvc_gate i_gate (
        .rst_act (rst_act),
        .at_top  (at_top),
        .en_n    (en_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/ensvc_chk.sv
module ensvc_chk #(
    parameter int unsigned NEED = 3,
    parameter int unsigned W    = 2
) (
    input logic         clk,
    input logic         por_n,
    input logic         wd_rst_n,
    input logic         svc_ok,
    input logic         en_n,
    input logic [W-1:0] cnt_q
);
    // R2: an active reset level always withdraws the enable
    a_r2_rst_blocks_en: assert property (@(posedge clk) disable iff (!por_n)
        !wd_rst_n |-> en_n);

    // R3, R4: a sampled reset clears the count, strobe or not
    a_r3_rst_clears: assert property (@(posedge clk) disable iff (!por_n)
        !wd_rst_n |=> (cnt_q == '0));

    // R5: an active enable implies the full count
    a_r5_en_needs_full: assert property (@(posedge clk) disable iff (!por_n)
        !en_n |-> (cnt_q == W'(NEED)));

    // R6: without a strobe and without reset the count holds
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!por_n)
        (wd_rst_n && !svc_ok) |=> $stable(cnt_q));

    // R7: the count never passes the saturation value
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= W'(NEED));

    // R8: once granted, the enable is withdrawn only by a reset level
    a_r8_drop_only_on_rst: assert property (@(posedge clk) disable iff (!por_n)
        $rose(en_n) |-> !wd_rst_n);
endmodule

bind ensvc_top ensvc_chk #(.NEED(NEED), .W(W)) i_ensvc_chk (
    .clk      (clk),
    .por_n    (por_n),
    .wd_rst_n (wd_rst_n),
    .svc_ok   (svc_ok),
    .en_n     (en_n),
    .cnt_q    (cnt_q)
);

// File: tb/test_ensvc_top.sv
module test_ensvc_top;
    localparam int unsigned NEED = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic wd_rst_n = 1'b0;
    logic svc_ok = 1'b0;
    logic en_n;

    int n_checks = 0;
    int n_errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ensvc_top #(.NEED(NEED)) i_ensvc_top (
        .clk      (clk),
        .por_n    (por_n),
        .wd_rst_n (wd_rst_n),
        .svc_ok   (svc_ok),
        .en_n     (en_n)
    );

    function automatic int model_next(int c, logic rn, logic s);
        if (!rn) return 0;
        if (s && c < NEED) return c + 1;
        return c;
    endfunction

    function automatic logic model_en_n(int c, logic rn);
        return (!rn) || (c != NEED);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: en_n actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, check en_n combinationally, then advance the model.
    task automatic step(logic rn, logic s, string req);
        @(negedge clk);
        wd_rst_n = rn;
        svc_ok   = s;
        #1;
        check(req, en_n, model_en_n(exp_cnt, rn));
        exp_cnt = model_next(exp_cnt, rn, s);
    endtask

    initial begin
        int limit = 0;
        while (!done && limit < 100000) begin
            @(posedge clk);
            limit++;
        end
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: power-up reset state
        wd_rst_n = 1'b1;
        svc_ok   = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", en_n, 1'b1);
        end
        @(negedge clk);
        svc_ok = 1'b0;
        por_n  = 1'b1;
        exp_cnt = 0;

        // R1/R6: count starts at zero; two strobes leave enable off
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        // R5: third strobe grants enable in the next cycle
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, "R5");
        // R7: saturation keeps enable on
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, "R7");
        // R2/R8: reset withdraws enable the same cycle
        step(1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, "R8");
        // R3: partial count (2) cleared by reset
        step(1'b0, 1'b0, "R3");
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R3");
        // R4: strobes during reset, incl. the asserting cycle, do not count
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b0, "R5");

        // Random phase, fixed seed
        begin
            int seed_dummy = $urandom(32'h5eed_0a17);
            seed_dummy = seed_dummy + 0;
        end
        for (int i = 0; i < 3000; i++) begin
            logic rn = ($urandom_range(0, 19) != 0);
            logic s  = ($urandom_range(0, 2) == 0);
            string req;
            if (!rn) req = "R2";
            else if (exp_cnt == NEED) req = "R7";
            else req = "R6";
            step(rn, s, req);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule